// File: doc/BRIEF.md
# Offset-Plus-One Magnitude Comparator

This block compares an unsigned operand `opa` against the successor of a second unsigned operand `opb`. It reports the result on five relation flags, for greater, greater-or-equal, less, less-or-equal and equal. A sixth flag reports when the successor of `opb` does not fit in the operand width. In that case the successor is undefined, so all five relation flags are held at zero and only the overflow flag is raised.

The operand width is the parameter `WIDTH`, with a default of 4. The parameter `REGISTERED` selects where the flags come from. When it is 1 (the default), all six flags are captured on the rising clock edge and cleared by a synchronous active-high reset. When it is 0, the flags follow the operands combinationally and the clock and reset are not used.

Top module: `cmp_offset_top`

## Requirements
- R1: With no overflow, `eq_o` is 1 exactly when `opa` equals `opb`+1.
- R2: With no overflow, `gt_o` is 1 exactly when `opa` > `opb`+1, and `lt_o` is 1 exactly when `opa` < `opb`+1.
- R3: With no overflow, `ge_o` is 1 exactly when `opa` >= `opb`+1, and `le_o` is 1 exactly when `opa` <= `opb`+1.
- R4: `ovf_o` is 1 exactly when `opb` is all ones (2^WIDTH-1), whatever the value of `opa`.
- R5: While `ovf_o` is 1, all five relation flags are 0.
- R6: While `ovf_o` is 0, exactly one of `gt_o`, `eq_o` and `lt_o` is 1; `ge_o` equals `gt_o` OR `eq_o`, and `le_o` equals `lt_o` OR `eq_o`.
- R7: For `opa`=9 and `opb`=5, only `gt_o` and `ge_o` are 1, and all other flags, `ovf_o` included, are 0.
- R8: With `REGISTERED`=1, each flag changes only on a rising clock edge and shows the result for the operands sampled at that edge. With `REGISTERED`=0, the flags follow the operands within the same cycle.
- R9: With `REGISTERED`=1, a clock edge at which `rst` is 1 clears all six flags to 0, whatever the operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register stage |
| rst | input | 1 | Synchronous active-high reset of the output register stage |
| opa | input | WIDTH | Unsigned operand compared against the successor |
| opb | input | WIDTH | Unsigned operand whose successor is the reference |
| gt_o | output | 1 | `opa` greater than `opb`+1 |
| ge_o | output | 1 | `opa` greater than or equal to `opb`+1 |
| lt_o | output | 1 | `opa` less than `opb`+1 |
| le_o | output | 1 | `opa` less than or equal to `opb`+1 |
| eq_o | output | 1 | `opa` equal to `opb`+1 |
| ovf_o | output | 1 | Successor of `opb` does not fit in WIDTH bits |

## Verification
An exhaustive sweep of all 256 operand pairs at width 4 drives both the combinational and the registered build. The sweep places every `opa` on each side of the successor, and it places every `opb` value, all-ones included, against every `opa`. This separates a wrong offset, swapped strict and non-strict flags, and overflow gating keyed to the wrong `opb` value.

Seeded random pairs and directed cases follow the sweep. The directed cases cover the 9/5 example, `opa` equal to `opb`+1, and `opb` of zero. A check taken before each clock edge, with new operands applied, shows that the registered flags still hold the previous result. This separates a one-cycle stage from a transparent one. Holding reset with operands that would raise flags shows whether the clear happens.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

    typedef struct packed {
        logic ovf;
        logic gt;
        logic ge;
        logic lt;
        logic le;
        logic eq;
    } cmp_flags_t;

    localparam cmp_flags_t CMP_FLAGS_CLEAR = '{default: 1'b0};

    function automatic cmp_flags_t cmp_gate(input cmp_flags_t raw, input logic ovf);
        cmp_flags_t res;
        res = ovf ? CMP_FLAGS_CLEAR : raw;
        res.ovf = ovf;
        return res;
    endfunction

endpackage

// File: rtl/cmp_incr.sv
module cmp_incr #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] val,
    output logic [WIDTH:0]   succ
);
    localparam int EXT = WIDTH + 1;

    always_comb begin
        succ = {1'b0, val} + EXT'(1);
    end
endmodule

// File: rtl/cmp_relate.sv
module cmp_relate
    import cmp_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH:0]   succ,
    output cmp_flags_t       flags
);
    logic [WIDTH:0] opa_ext;
    logic           above;
    logic           same;
    logic           below;
    cmp_flags_t     raw;

    always_comb begin
        opa_ext = {1'b0, opa};
        above   = opa_ext > succ;
        same    = opa_ext == succ;
        below   = opa_ext < succ;
        raw     = CMP_FLAGS_CLEAR;
        raw.gt  = above;
        raw.ge  = above | same;
        raw.lt  = below;
        raw.le  = below | same;
        raw.eq  = same;
        flags   = cmp_gate(raw, succ[WIDTH]);
    end
endmodule

// File: rtl/cmp_stage.sv
module cmp_stage
    import cmp_pkg::*;
#(
    parameter bit REGISTERED = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  cmp_flags_t d,
    output cmp_flags_t q
);
    generate
        if (REGISTERED) begin : g_reg
            cmp_flags_t held;
            always_ff @(posedge clk) begin
                if (rst) begin
                    held <= CMP_FLAGS_CLEAR;
                end else begin
                    held <= d;
                end
            end
            assign q = held;
        end else begin : g_comb
            assign q = d;
        end
    endgenerate
endmodule

// File: rtl/cmp_offset_top.sv
module cmp_offset_top
    import cmp_pkg::*;
#(
    parameter int WIDTH      = 4,
    parameter bit REGISTERED = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    output logic             gt_o,
    output logic             ge_o,
    output logic             lt_o,
    output logic             le_o,
    output logic             eq_o,
    output logic             ovf_o
);
    logic [WIDTH:0] succ;
    cmp_flags_t     flags_now;
    cmp_flags_t     flags_out;

    cmp_incr #(.WIDTH(WIDTH)) incr_i (
        .val  (opb),
        .succ (succ)
    );

    cmp_relate #(.WIDTH(WIDTH)) relate_i (
        .opa   (opa),
        .succ  (succ),
        .flags (flags_now)
    );

    cmp_stage #(.REGISTERED(REGISTERED)) stage_i (
        .clk (clk),
        .rst (rst),
        .d   (flags_now),
        .q   (flags_out)
    );

    assign gt_o  = flags_out.gt;
    assign ge_o  = flags_out.ge;
    assign lt_o  = flags_out.lt;
    assign le_o  = flags_out.le;
    assign eq_o  = flags_out.eq;
    assign ovf_o = flags_out.ovf;
endmodule

// File: rtl/cmp_offset_chk.sv
module cmp_offset_chk #(
    parameter int WIDTH      = 4,
    parameter bit REGISTERED = 1'b1
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] opa,
    input logic [WIDTH-1:0] opb,
    input logic             gt_o,
    input logic             ge_o,
    input logic             lt_o,
    input logic             le_o,
    input logic             eq_o,
    input logic             ovf_o
);
    logic [WIDTH-1:0] a_seen;
    logic [WIDTH-1:0] b_seen;
    logic [WIDTH:0]   b_next;

    generate
        if (REGISTERED) begin : g_delay
            logic [WIDTH-1:0] a_q;
            logic [WIDTH-1:0] b_q;
            always_ff @(posedge clk) begin
                a_q <= opa;
                b_q <= opb;
            end
            assign a_seen = a_q;
            assign b_seen = b_q;

            AST_RESET_CLEARS: assert property (@(posedge clk)
                rst |=> !(gt_o | ge_o | lt_o | le_o | eq_o | ovf_o)); // R9
        end else begin : g_direct
            assign a_seen = opa;
            assign b_seen = opb;
        end
    endgenerate

    assign b_next = {1'b0, b_seen} + 1'b1;

    AST_EQ_MATCH: assert property (@(posedge clk) disable iff (rst)
        eq_o |-> ({1'b0, a_seen} == b_next)); // R1
    AST_GT_MATCH: assert property (@(posedge clk) disable iff (rst)
        gt_o |-> ({1'b0, a_seen} > b_next)); // R2
    AST_LT_MATCH: assert property (@(posedge clk) disable iff (rst)
        lt_o |-> ({1'b0, a_seen} < b_next)); // R2
    AST_OVF_SOURCE: assert property (@(posedge clk) disable iff (rst)
        ovf_o |-> (&b_seen)); // R4
    AST_OVF_SILENCES: assert property (@(posedge clk) disable iff (rst)
        ovf_o |-> !(gt_o | ge_o | lt_o | le_o | eq_o)); // R5
    AST_ONE_RELATION: assert property (@(posedge clk) disable iff (rst)
        (!ovf_o && !$past(rst)) |-> $countones({gt_o, eq_o, lt_o}) == 1); // R6
    AST_GE_COMPOSE: assert property (@(posedge clk) disable iff (rst)
        ge_o == (gt_o | eq_o)); // R3
    AST_LE_COMPOSE: assert property (@(posedge clk) disable iff (rst)
        le_o == (lt_o | eq_o)); // R3
endmodule

bind cmp_offset_top cmp_offset_chk #(.WIDTH(WIDTH), .REGISTERED(REGISTERED)) chk_i (
    .clk   (clk),
    .rst   (rst),
    .opa   (opa),
    .opb   (opb),
    .gt_o  (gt_o),
    .ge_o  (ge_o),
    .lt_o  (lt_o),
    .le_o  (le_o),
    .eq_o  (eq_o),
    .ovf_o (ovf_o)
);

// File: tb/cmp_offset_top_tb_top.sv
module cmp_offset_top_tb_top;
    localparam int W        = 4;
    localparam int CLK_HALF = 5;
    localparam int SPAN     = 1 << W;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] opa = '0;
    logic [W-1:0] opb = '0;

    logic [5:0] comb_f;
    logic [5:0] reg_f;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #CLK_HALF clk = ~clk;

    // combinational build, flag order {ovf,gt,ge,lt,le,eq}
    cmp_offset_top #(.WIDTH(W), .REGISTERED(1'b0)) dut_i (
        .clk(clk), .rst(rst), .opa(opa), .opb(opb),
        .gt_o(comb_f[4]), .ge_o(comb_f[3]), .lt_o(comb_f[2]),
        .le_o(comb_f[1]), .eq_o(comb_f[0]), .ovf_o(comb_f[5])
    );

    cmp_offset_top #(.WIDTH(W), .REGISTERED(1'b1)) dut_reg_i (
        .clk(clk), .rst(rst), .opa(opa), .opb(opb),
        .gt_o(reg_f[4]), .ge_o(reg_f[3]), .lt_o(reg_f[2]),
        .le_o(reg_f[1]), .eq_o(reg_f[0]), .ovf_o(reg_f[5])
    );

    function automatic logic [5:0] model(input int a, input int b);
        int s;
        s = b + 1;
        if (s >= SPAN) return 6'b100000;
        return {1'b0, a > s, a >= s, a < s, a <= s, a == s};
    endfunction

    task automatic check(input string req, input logic [5:0] got, input logic [5:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s a=%0d b=%0d got=%b exp=%b", req, opa, opb, got, exp);
        end
    endtask

    // apply at negedge, check comb now, registered after the next edge
    task automatic apply(input int a, input int b, input string req);
        logic [5:0] prev;
        @(negedge clk);
        prev = reg_f;
        opa = W'(a);
        opb = W'(b);
        #1;
        check(req, comb_f, model(a, b));
        check("R8 hold", reg_f, prev);
        @(posedge clk);
        #1;
        check({req, " R8"}, reg_f, model(a, b));
    endtask

    initial begin
        #(CLK_HALF * 2 * 20000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 1234;
        void'($urandom(seed));
        opa = 4'd9;
        opb = 4'd5;
        repeat (3) @(posedge clk);
        #1;
        check("R9 reset clear", reg_f, 6'b000000);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check("R7 registered", reg_f, 6'b011000);
        apply(9, 5, "R7");
        check("R7 literal", comb_f, 6'b011000);
        apply(6, 5, "R1 eq");
        check("R1 eq literal", comb_f, 6'b001011);
        apply(0, 0, "R2 lt b=0");
        apply(15, 15, "R4 R5 ovf");
        check("R5 literal", comb_f, 6'b100000);
        for (int a = 0; a < SPAN; a++) begin
            for (int b = 0; b < SPAN; b++) begin
                apply(a, b, "R1 R2 R3 R6 sweep");
                n_checks++;
                if (comb_f[5] !== (b == SPAN - 1)) begin
                    n_fail++;
                    $display("FAIL R4 a=%0d b=%0d got=%b exp=%b", a, b, comb_f[5], (b == SPAN - 1));
                end
            end
        end
        for (int i = 0; i < 1000; i++) begin
            apply(int'($urandom_range(SPAN - 1)), int'($urandom_range(SPAN - 1)), "R2 R3 random");
        end
        @(negedge clk);
        rst = 1'b1;
        opa = 4'd12;
        opb = 4'd3;
        @(posedge clk);
        #1;
        check("R9 mid-run reset", reg_f, 6'b000000);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule